// File: doc/BRIEF.md
# SPI Command Engine with Ring Buffer

This block is a byte-wide, register-driven SPI master that runs one flash-style transaction per command. Software loads an opcode register and a count register. It loads the bytes to transmit into an eight-entry ring buffer through a single data port, then sets the execute bit. The engine lowers chip select and shifts out the opcode. It then sends the write bytes taken from the ring, followed by filler bytes while it collects the response. Every byte clocked in after the opcode lands back in the ring.

The ring is shared by both directions and is never cleared by a transaction. Its pointer is rewound with a self-clearing control bit and can be read back. Software therefore rewinds the pointer, skips the entries that held its write bytes, and reads the response through the same data port. Serial timing is SPI mode 0 with the most significant bit first. The serial clock half-period is a fixed number of system clocks, set by the `HALF_DIV` parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the opcode, count and control registers, every ring entry and the ring pointer read 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A write to offset 0xC stores the byte at the ring pointer and advances the pointer. A read of offset 0xC returns the byte at the pointer and advances it. The pointer wraps modulo 8 and reads back in bits [2:0] of offset 0xD.
- R3: Writing 1 to bit 4 of offset 2 sets the pointer to 0 on the next cycle. That bit always reads back as 0.
- R4: Writing 1 to bit 0 of offset 2 starts a transaction. The bit reads 1 while the transaction runs, and hardware clears it in the same cycle that chip select is released.
- R5: A transaction shifts out the opcode from offset 0 first, MSB first. It then sends the write-count bytes from ring entries 0, 1, and so on, then one 0xFF filler byte per read-count byte, and no other bytes.
- R6: Offset 1 holds the write count in bits [3:0] and the read count in bits [7:4]. The engine treats any count above 8 as 8.
- R7: The k-th byte received after the opcode (k counted from 1) overwrites ring entry (k-1) mod 8, so read data follows the write entries. Entries beyond that are left unchanged.
- R8: An opcode-only command with a non-zero read count captures every requested response byte, including the last one.
- R9: Mode 0 timing applies. `spi_sclk` idles low, `spi_mosi` changes only while `spi_sclk` is low, `spi_miso` is sampled on the rising edge, and each high phase lasts `HALF_DIV` clocks.
- R10: Chip select goes low at least one half-period before the first rising edge and goes high at least one half-period after the last falling edge. `spi_sclk` stays low while chip select is high.
- R11: While the execute bit is set, writes to offsets 0, 1 and 0xC have no effect on the registers, the ring or the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle per byte |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe; a read of the data port advances the pointer |
| reg_rdata | output | 8 | Read data for `reg_addr`, valid in the same cycle |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Directed transactions cover four cases: an opcode-only read, a mixed write and read, full eight-plus-eight counts, and over-limit counts. Together they separate a dropped last byte, a wrong storage index, and a clamp failure. A data-port burst of ten bytes tells correct pointer wrap apart from saturation, and register pokes during a busy transaction show whether writes are gated. Seeded random opcodes, counts and payloads then run back to back on a ring that is never cleared. A bench model of the ring predicts the transmitted stream and every entry, so stale-entry handling is also compared.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int RING_DEPTH = 8;
  localparam int PTR_W      = $clog2(RING_DEPTH);
  localparam int MAX_XFER   = 8;
  localparam int STEP_W     = 5;

  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNTS = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_REWIND_BIT = 4;

  localparam logic [7:0] FILLER = 8'hFF;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} shift_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_TAIL} seq_state_t;

  function automatic logic [3:0] clamp_count(input logic [3:0] raw);
    return (raw > 4'(MAX_XFER)) ? 4'(MAX_XFER) : raw;
  endfunction
endpackage

// File: rtl/spi_cmd_ring.sv
module spi_cmd_ring
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic             sw_adv,
  input  logic             ptr_clr,
  input  logic [7:0]       sw_wdata,
  output logic [7:0]       sw_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_idx,
  input  logic [7:0]       eng_wdata,
  output logic [7:0]       eng_rdata
);
  logic [7:0]       slot_q [RING_DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_clr)               ptr_d = '0;
    else if (sw_wr || sw_adv)  ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < RING_DEPTH; i++) begin : g_slot
    logic       slot_en;
    logic [7:0] slot_d;
    always_comb begin
      slot_en = (eng_we && eng_idx == PTR_W'(i)) || (sw_wr && ptr_q == PTR_W'(i));
      slot_d  = eng_we ? eng_wdata : sw_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_en) slot_q[i] <= slot_d;
    end
  end

  assign sw_rdata  = slot_q[ptr_q];
  assign eng_rdata = slot_q[eng_idx];
  assign ptr       = ptr_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_DIV - 1);

  shift_state_t st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sr_q, sr_d, rx_q, rx_d;
  logic sclk_q, sclk_d;
  logic half_end;

  assign half_end = (cnt_q == HALF_LAST);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q;
    sr_d = sr_q; rx_d = rx_q; sclk_d = sclk_q;
    byte_done = 1'b0;
    case (st_q)
      SH_IDLE: if (go) begin
        st_d = SH_LOW; cnt_d = '0; bit_d = '0; sr_d = tx_byte; sclk_d = 1'b0;
      end
      SH_LOW: begin
        if (half_end) begin
          st_d = SH_HIGH; cnt_d = '0; sclk_d = 1'b1;
          rx_d = {rx_q[6:0], miso};
        end else cnt_d = cnt_q + 1'b1;
      end
      SH_HIGH: begin
        if (half_end) begin
          cnt_d = '0; sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            st_d = SH_IDLE; byte_done = 1'b1;
          end else begin
            st_d = SH_LOW; bit_d = bit_q + 1'b1; sr_d = {sr_q[6:0], 1'b0};
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SH_IDLE; cnt_q <= '0; bit_q <= '0;
      sr_q <= '0; rx_q <= '0; sclk_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d;
      sr_q <= sr_d; rx_q <= rx_d; sclk_q <= sclk_d;
    end
  end

  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = sr_q[7];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       wr_cnt,
  input  logic [3:0]       rd_cnt,
  input  logic [7:0]       opcode,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             eng_we,
  output logic [PTR_W-1:0] eng_idx,
  output logic [7:0]       eng_wdata,
  input  logic [7:0]       eng_rdata,
  output logic             cs_n,
  output logic             finish
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_DIV - 1);

  seq_state_t st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d, total_q, total_d;
  logic [3:0] wc_q, wc_d;
  logic [DIV_W-1:0] tail_q, tail_d;
  logic cs_n_q, cs_n_d;

  assign eng_idx   = PTR_W'(step_q - 1'b1);
  assign eng_wdata = sh_rx;
  assign sh_go     = (st_q == SQ_LAUNCH);
  assign eng_we    = (st_q == SQ_WAIT) && sh_done && (step_q != '0);

  always_comb begin
    if (step_q == '0)                    sh_tx = opcode;
    else if (step_q <= {1'b0, wc_q})     sh_tx = eng_rdata;
    else                                 sh_tx = FILLER;
  end

  always_comb begin
    st_d = st_q; step_d = step_q; total_d = total_q;
    wc_d = wc_q; tail_d = tail_q; cs_n_d = cs_n_q;
    finish = 1'b0;
    case (st_q)
      SQ_IDLE: if (start) begin
        st_d = SQ_LAUNCH; step_d = '0; wc_d = wr_cnt; cs_n_d = 1'b0;
        total_d = STEP_W'(1) + {1'b0, wr_cnt} + {1'b0, rd_cnt};
      end
      SQ_LAUNCH: st_d = SQ_WAIT;
      SQ_WAIT: if (sh_done) begin
        step_d = step_q + 1'b1;
        if (step_q + 1'b1 == total_q) begin
          st_d = SQ_TAIL; tail_d = '0;
        end else st_d = SQ_LAUNCH;
      end
      SQ_TAIL: begin
        if (tail_q == HALF_LAST) begin
          st_d = SQ_IDLE; cs_n_d = 1'b1; finish = 1'b1;
        end else tail_d = tail_q + 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; step_q <= '0; total_q <= '0;
      wc_q <= '0; tail_q <= '0; cs_n_q <= 1'b1;
    end else begin
      st_q <= st_d; step_q <= step_d; total_q <= total_d;
      wc_q <= wc_d; tail_q <= tail_d; cs_n_q <= cs_n_d;
    end
  end

  assign cs_n = cs_n_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [7:0] opcode_q, opcode_d, counts_q, counts_d;
  logic       exec_q, exec_d;
  logic       ctrl_wr, start, rewind, data_wr, data_rd, finish;
  logic [PTR_W-1:0] ring_ptr, eng_idx;
  logic [7:0] ring_rdata, eng_rdata, eng_wdata, sh_tx, sh_rx;
  logic       eng_we, sh_go, sh_done;

  always_comb begin
    ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
    start    = ctrl_wr && reg_wdata[CTRL_RUN_BIT] && !exec_q;
    rewind   = ctrl_wr && reg_wdata[CTRL_REWIND_BIT];
    data_wr  = reg_wr && (reg_addr == OFS_DATA) && !exec_q;
    data_rd  = reg_rd && (reg_addr == OFS_DATA) && !data_wr;
    opcode_d = (reg_wr && reg_addr == OFS_OPCODE && !exec_q) ? reg_wdata : opcode_q;
    counts_d = (reg_wr && reg_addr == OFS_COUNTS && !exec_q) ? reg_wdata : counts_q;
    exec_d   = exec_q;
    if (start)       exec_d = 1'b1;
    else if (finish) exec_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      opcode_q <= '0; counts_q <= '0; exec_q <= 1'b0;
    end else begin
      opcode_q <= opcode_d; counts_q <= counts_d; exec_q <= exec_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_OPCODE: reg_rdata = opcode_q;
      OFS_COUNTS: reg_rdata = counts_q;
      OFS_CTRL:   reg_rdata = {7'b0, exec_q};
      OFS_DATA:   reg_rdata = ring_rdata;
      OFS_PTR:    reg_rdata = {{(8-PTR_W){1'b0}}, ring_ptr};
      default:    reg_rdata = '0;
    endcase
  end

  spi_cmd_ring u_ring (
    .clk(clk), .rst_n(srst_n),
    .sw_wr(data_wr), .sw_adv(data_rd), .ptr_clr(rewind),
    .sw_wdata(reg_wdata), .sw_rdata(ring_rdata), .ptr(ring_ptr),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  spi_cmd_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start),
    .wr_cnt(clamp_count(counts_q[3:0])), .rd_cnt(clamp_count(counts_q[7:4])),
    .opcode(opcode_q), .sh_go(sh_go), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .cs_n(spi_cs_n), .finish(finish)
  );

  spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(srst_n), .go(sh_go), .tx_byte(sh_tx),
    .byte_done(sh_done), .rx_byte(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       reg_addr,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic             exec_q,
  input logic [7:0]       opcode_q,
  input logic [7:0]       counts_q,
  input logic [PTR_W-1:0] ring_ptr,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             spi_mosi
);
  assert_cs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_q |-> spi_cs_n);

  assert_sclk_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_ptr_rewind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && reg_wdata[CTRL_REWIND_BIT]) |=> (ring_ptr == '0));

  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_regs_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && $past(exec_q)) |-> ($stable(opcode_q) && $stable(counts_q)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .exec_q(exec_q), .opcode_q(opcode_q),
  .counts_q(counts_q), .ring_ptr(ring_ptr), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  localparam int HALF = 2;
  localparam int HALF_NS = HALF * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HALF)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] resp [0:16];
  logic [7:0] mlog [0:16];
  int sbit = 0, frame_bits = 0;
  time t_cs_fall, t_cs_rise, t_first_rise, t_rise, t_last_fall, hi_w;

  assign spi_miso = (sbit < 136) ? resp[sbit >> 3][7 - (sbit & 7)] : 1'b0;

  always @(negedge spi_cs_n) t_cs_fall = $time;
  always @(posedge spi_cs_n) t_cs_rise = $time;
  always @(negedge spi_sclk) begin t_last_fall = $time; hi_w = $time - t_rise; end
  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      frame_bits = sbit; sbit = 0;
    end else begin
      if (sbit == 0) t_first_rise = $time;
      t_rise = $time;
      if (sbit < 136) mlog[sbit >> 3] = {mlog[sbit >> 3][6:0], spi_mosi};
      sbit = sbit + 1;
    end
  end

  logic [7:0] ref_ring [8];
  int ref_ptr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic int clampc(input int v);
    return (v > 8) ? 8 : v;
  endfunction

  task automatic check_ring(input string req);
    logic [7:0] v;
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v);
      chk(req, v, ref_ring[i]);
    end
    rd(4'hD, v);
    chk("R2 wrap", v, 8'd0);
    ref_ptr = 0;
  endtask

  task automatic run_xfer(input logic [7:0] op, input logic [7:0] cnt, input bit poke);
    logic [7:0] v;
    logic [7:0] exp_tx [0:16];
    int wc, rc, total, polls;
    wc = clampc(int'(cnt[3:0])); rc = clampc(int'(cnt[7:4])); total = 1 + wc + rc;
    wr(4'h0, op); wr(4'h1, cnt); wr(4'h2, 8'h10); ref_ptr = 0;
    for (int i = 0; i < wc; i++) begin
      v = 8'($urandom);
      wr(4'hC, v); ref_ring[ref_ptr] = v; ref_ptr = (ref_ptr + 1) % 8;
    end
    rd(4'hD, v); chk("R2 pointer", v, 8'(ref_ptr));
    wr(4'h2, 8'h10); ref_ptr = 0;
    for (int k = 0; k < 17; k++) resp[k] = 8'($urandom);
    exp_tx[0] = op;
    for (int k = 1; k < 17; k++) exp_tx[k] = (k <= wc) ? ref_ring[k-1] : 8'hFF;
    wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R4 busy", v, 8'h01);
    if (poke) begin
      wr(4'h0, ~op); wr(4'h1, 8'h00); wr(4'hC, 8'hA5);
    end
    polls = 0;
    do begin rd(4'h2, v); polls++; end while (v[0] && polls < 4000);
    chk("R4 cleared", v, 8'h00);
    chk((wc == 0 && rc > 0) ? "R8 bit count" : "R5 bit count", frame_bits, total * 8);
    for (int k = 0; k < total; k++) chk("R5 mosi byte", mlog[k], exp_tx[k]);
    chk("R10 lead", (t_first_rise - t_cs_fall) >= HALF_NS, 1);
    chk("R10 tail", (t_cs_rise - t_last_fall) >= HALF_NS, 1);
    chk("R9 high width", hi_w, HALF_NS);
    for (int k = 1; k < total; k++) ref_ring[(k-1) % 8] = resp[k];
    rd(4'h0, v); chk("R11 opcode", v, op);
    rd(4'h1, v); chk("R11 counts", v, cnt);
    rd(4'hD, v); chk("R11 pointer", v, 8'd0);
    check_ring((wc == 0 && rc > 0) ? "R8 capture" : (cnt != 8'(rc*16+wc)) ? "R6 clamp" : "R7 ring");
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seed_drop;
    seed_drop = $urandom(32'd2024);
    for (int i = 0; i < 8; i++) ref_ring[i] = 8'h00;
    for (int k = 0; k < 17; k++) resp[k] = 8'h00;
    ref_ptr = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 cs_n", spi_cs_n, 1); chk("R1 sclk", spi_sclk, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk("R1 opcode", v, 0);
    rd(4'h1, v); chk("R1 counts", v, 0);
    rd(4'h2, v); chk("R1 ctrl", v, 0);
    rd(4'hD, v); chk("R1 pointer", v, 0);
    rd(4'hC, v); chk("R1 ring", v, 0);
    wr(4'h2, 8'h10);
    rd(4'hD, v); chk("R3 rewind", v, 0);
    rd(4'h2, v); chk("R3 self clear", v, 0);
    for (int i = 0; i < 10; i++) begin
      wr(4'hC, 8'(8'h30 + i)); ref_ring[ref_ptr] = 8'(8'h30 + i); ref_ptr = (ref_ptr + 1) % 8;
    end
    rd(4'hD, v); chk("R2 wrap pointer", v, 8'd2);
    check_ring("R2 data port");
    run_xfer(8'h9F, 8'h30, 1'b0);
    run_xfer(8'h05, 8'h10, 1'b0);
    run_xfer(8'h03, 8'h53, 1'b1);
    run_xfer(8'h0B, 8'h88, 1'b0);
    run_xfer(8'hAB, 8'hCF, 1'b1);
    run_xfer(8'h06, 8'h00, 1'b0);
    for (int t = 0; t < 20; t++)
      run_xfer(8'($urandom), {4'($urandom % 9), 4'($urandom % 9)}, 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule